// File: doc/BRIEF.md
# Pipelined Page Cache Read Engine

This block models the device side of a cached sequential page read. It has two page-wide stages: a data register, filled from an array read port with a fixed latency, and a cache register, from which bytes are streamed to the host. A command strobe interface carries command bytes and address bytes. An active-low busy output tells the host when a command may be issued.

A normal read fills the data register. A cache-start command moves the data register into the cache register and at once starts loading the next sequential page in the background. Bytes are read out of the cache register while that background load runs. A last-page command moves the final page across and starts no further load. The array contents come from an arithmetic pattern, so the block needs no memory file.

The host issues a normal read once. It then alternates between reading out the cache register and issuing cache-start commands. If the host is faster than the array, each cache-start waits out the remainder of the background load.

Top module: `cache_read_engine`

## Requirements
- R1: After reset, busy_n is 1, err_flag is 0, boundary_flag is 0 and rd_data is 0.
- R2: Command 00h, followed by ceil(PAGE_AW/8) address bytes (page number, least significant byte first) and then command 30h, holds busy_n low for exactly READ_LAT cycles and loads that page into the data register. The cache register and rd_data are left unchanged, and boundary_flag is cleared.
- R3: Byte c of page p in the array is (37*p + 5*c + 1) mod 256. Command 31h with a valid data register copies it into the cache register and holds busy_n low for exactly COPY_LAT cycles. In the cycle the copy is accepted, it starts an array read of page p+1.
- R4: rd_data shows the cache byte at the column pointer. A rd_strobe sampled while busy_n is 1 advances the pointer, and the pointer wraps from PAGE_BYTES-1 to 0. A strobe sampled while busy_n is 0 has no effect.
- R5: If 31h (or 3Fh) is accepted at clock edge k while a background read that completes at edge D is still pending (k <= D), busy_n stays low until edge D+1+COPY_LAT. The copy happens at edge D+1.
- R6: Every copy into the cache register resets the column pointer to 0, even when the previous page was only partly read.
- R7: Command 3Fh copies the data register into the cache register with COPY_LAT busy cycles and starts no array read. A later 31h therefore finds no page.
- R8: A 31h or 3Fh that finds neither a valid data register nor a pending read is ignored: busy_n stays 1 and rd_data is unchanged. It also sets err_flag, which stays set until reset.
- R9: When a 31h copies page p and p+1 is a multiple of 2^BLK_LG2 (a block edge), no prefetch starts and boundary_flag is set. The flag holds until the next accepted 30h.
- R10: Commands are ignored while busy_n is 0, and unknown command bytes are ignored. A 30h without a preceding 00h and full address is ignored. A 00h is ignored while a background read is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command or address byte is present this cycle |
| cmd_is_addr | input | 1 | 1: cmd_byte is an address byte; 0: a command byte |
| cmd_byte | input | 8 | Command or address byte |
| rd_strobe | input | 1 | Advance the output column by one |
| rd_data | output | 8 | Cache register byte at the current column |
| busy_n | output | 1 | 1 when ready to accept commands, 0 while busy |
| err_flag | output | 1 | Sticky: a cache command found no page |
| boundary_flag | output | 1 | Prefetch stopped at a block edge |

## Verification
The hardest situation to reach is a cache-start command that arrives while the background read is still pending. This is most sensitive when the command lands on the very edge where that read completes, because the busy length then depends on the exact distance between the two events. The bench reaches this by sweeping the starting page across two blocks and varying how far each page is read out before the next command: a full read with wrap, a partial read, strobes held during busy, and foreign commands injected while the prefetch runs. A cycle counter records every acceptance edge, and the expected busy length is recomputed from those edge numbers.

// File: rtl/cre_pkg.sv
package cre_pkg;
   localparam logic [7:0] OP_READ    = 8'h00;
   localparam logic [7:0] OP_CONFIRM = 8'h30;
   localparam logic [7:0] OP_CACHE   = 8'h31;
   localparam logic [7:0] OP_LAST    = 8'h3F;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_LOAD,
      ST_WAIT,
      ST_COPY
   } cre_state_e;
endpackage

// File: rtl/cre_array_model.sv
module cre_array_model #(
   parameter int PAGE_AW    = 10,
   parameter int PAGE_BYTES = 16,
   parameter int READ_LAT   = 20,
   parameter int PAT_MUL    = 37,
   parameter int PAT_STEP   = 5,
   parameter int PAT_OFS    = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      start,
   input  logic [PAGE_AW-1:0]        page,
   output logic                      busy,
   output logic                      done,
   output logic [PAGE_BYTES*8-1:0]   row
);
   localparam int RL_W = $clog2(READ_LAT + 1);

   logic [RL_W-1:0]    cnt_q;
   logic [PAGE_AW-1:0] page_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt_q  <= '0;
         page_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         cnt_q  <= RL_W'(READ_LAT - 1);
         page_q <= page;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = busy && (cnt_q == '0);

   // pattern source: one byte lane per column
   for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_lane
      assign row[8*c +: 8] = 8'((32'(page_q) * PAT_MUL) + (c * PAT_STEP) + PAT_OFS);
   end
endmodule

// File: rtl/cre_page_regs.sv
module cre_page_regs #(
   parameter int PAGE_BYTES = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic [PAGE_BYTES*8-1:0]   row,
   input  logic                      copy,
   input  logic                      strobe,
   input  logic                      ready,
   output logic [7:0]                rd_data
);
   localparam int COL_W = $clog2(PAGE_BYTES);

   logic [PAGE_BYTES*8-1:0] dreg_q;
   logic [PAGE_BYTES*8-1:0] cache_q;
   logic [COL_W-1:0]        col_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dreg_q <= '0;
      else if (load) dreg_q <= row;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cache_q <= '0;
         col_q   <= '0;
      end else if (copy) begin
         cache_q <= dreg_q;
         col_q   <= '0;
      end else if (strobe && ready) begin
         col_q   <= col_q + 1'b1;
      end
   end

   assign rd_data = cache_q[{col_q, 3'b000} +: 8];
endmodule

// File: rtl/cre_ctrl.sv
module cre_ctrl
   import cre_pkg::*;
#(
   parameter int PAGE_AW     = 10,
   parameter int BLK_LG2     = 2,
   parameter int ADDR_CYCLES = 2,
   parameter int COPY_LAT    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_is_addr,
   input  logic [7:0]         cmd_byte,
   input  logic               arr_busy,
   input  logic               arr_done,
   output logic               arr_start,
   output logic [PAGE_AW-1:0] arr_page,
   output logic               copy_fire,
   output logic               busy_n,
   output logic               err_flag,
   output logic               boundary_flag,
   output logic               dreg_valid
);
   localparam int CNT_W = $clog2(ADDR_CYCLES + 1);
   localparam int CL_W  = $clog2(COPY_LAT + 1);
   localparam logic [CNT_W-1:0] ACNT_MAX = CNT_W'(ADDR_CYCLES);

   cre_state_e         st_q, st_d;
   logic [CNT_W-1:0]   acnt_q, acnt_d;
   logic [PAGE_AW-1:0] acc_q, acc_d;
   logic [PAGE_AW-1:0] page_q, page_d;
   logic [CL_W-1:0]    ccnt_q, ccnt_d;
   logic               wlast_q, wlast_d;
   logic               err_q, err_d;
   logic               bnd_q, bnd_d;
   logic               dv_q, dv_d;
   logic               copy_req, copy_last;
   logic               is_cmd, is_adr, is_cache_op;
   logic [PAGE_AW-1:0] nxt_page;

   assign is_cmd      = cmd_valid && !cmd_is_addr;
   assign is_adr      = cmd_valid && cmd_is_addr;
   assign is_cache_op = (cmd_byte == OP_CACHE) || (cmd_byte == OP_LAST);
   assign nxt_page    = page_q + 1'b1;

   always_comb begin
      st_d      = st_q;
      acnt_d    = acnt_q;
      acc_d     = acc_q;
      page_d    = page_q;
      ccnt_d    = ccnt_q;
      wlast_d   = wlast_q;
      err_d     = err_q;
      bnd_d     = bnd_q;
      dv_d      = dv_q;
      arr_start = 1'b0;
      arr_page  = page_q;
      copy_fire = 1'b0;
      copy_req  = 1'b0;
      copy_last = 1'b0;

      if (arr_done) dv_d = 1'b1;

      unique case (st_q)
         ST_IDLE: begin
            if (is_cmd && cmd_byte == OP_READ && !arr_busy) begin
               st_d   = ST_ADDR;
               acnt_d = '0;
               acc_d  = '0;
            end else if (is_cmd && is_cache_op) begin
               if (dv_q) begin
                  copy_req  = 1'b1;
                  copy_last = (cmd_byte == OP_LAST);
               end else if (arr_busy) begin
                  st_d    = ST_WAIT;
                  wlast_d = (cmd_byte == OP_LAST);
               end else begin
                  err_d   = 1'b1;
               end
            end
         end
         ST_ADDR: begin
            if (is_adr && acnt_q < ACNT_MAX) begin
               acc_d  = acc_q | (PAGE_AW'(cmd_byte) << {acnt_q, 3'b000});
               acnt_d = acnt_q + 1'b1;
            end else if (is_cmd && cmd_byte == OP_READ) begin
               acnt_d = '0;
               acc_d  = '0;
            end else if (is_cmd && cmd_byte == OP_CONFIRM && acnt_q == ACNT_MAX) begin
               arr_start = 1'b1;
               arr_page  = acc_q;
               page_d    = acc_q;
               dv_d      = 1'b0;
               bnd_d     = 1'b0;
               st_d      = ST_LOAD;
            end
         end
         ST_LOAD: begin
            if (arr_done) st_d = ST_IDLE;
         end
         ST_WAIT: begin
            if (dv_q) begin
               copy_req  = 1'b1;
               copy_last = wlast_q;
            end
         end
         ST_COPY: begin
            if (ccnt_q == '0) st_d = ST_IDLE;
            else              ccnt_d = ccnt_q - 1'b1;
         end
         default: st_d = ST_IDLE;
      endcase

      if (copy_req) begin
         copy_fire = 1'b1;
         dv_d      = 1'b0;
         st_d      = ST_COPY;
         ccnt_d    = CL_W'(COPY_LAT - 1);
         if (!copy_last) begin
            if (nxt_page[BLK_LG2-1:0] == '0) begin
               bnd_d = 1'b1;
            end else begin
               arr_start = 1'b1;
               arr_page  = nxt_page;
               page_d    = nxt_page;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         acnt_q  <= '0;
         acc_q   <= '0;
         page_q  <= '0;
         ccnt_q  <= '0;
         wlast_q <= 1'b0;
         err_q   <= 1'b0;
         bnd_q   <= 1'b0;
         dv_q    <= 1'b0;
      end else begin
         st_q    <= st_d;
         acnt_q  <= acnt_d;
         acc_q   <= acc_d;
         page_q  <= page_d;
         ccnt_q  <= ccnt_d;
         wlast_q <= wlast_d;
         err_q   <= err_d;
         bnd_q   <= bnd_d;
         dv_q    <= dv_d;
      end
   end

   assign busy_n        = (st_q == ST_IDLE) || (st_q == ST_ADDR);
   assign err_flag      = err_q;
   assign boundary_flag = bnd_q;
   assign dreg_valid    = dv_q;
endmodule

// File: rtl/cache_read_engine.sv
module cache_read_engine #(
   parameter int PAGE_BYTES = 16,
   parameter int PAGE_AW    = 10,
   parameter int BLK_LG2    = 2,
   parameter int READ_LAT   = 20,
   parameter int COPY_LAT   = 3,
   parameter int PAT_MUL    = 37,
   parameter int PAT_STEP   = 5,
   parameter int PAT_OFS    = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       cmd_is_addr,
   input  logic [7:0] cmd_byte,
   input  logic       rd_strobe,
   output logic [7:0] rd_data,
   output logic       busy_n,
   output logic       err_flag,
   output logic       boundary_flag
);
   localparam int ADDR_CYCLES = (PAGE_AW + 7) / 8;

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 2");
   end
   if (BLK_LG2 < 1 || BLK_LG2 >= PAGE_AW) begin : g_bad_blk
      $error("BLK_LG2 must lie in 1..PAGE_AW-1");
   end
   if (READ_LAT < 1 || COPY_LAT < 1) begin : g_bad_lat
      $error("READ_LAT and COPY_LAT must be at least 1");
   end

   logic                    arr_start, arr_busy, arr_done;
   logic [PAGE_AW-1:0]      arr_page;
   logic [PAGE_BYTES*8-1:0] arr_row;
   logic                    copy_fire, dreg_valid;

   cre_ctrl #(
      .PAGE_AW(PAGE_AW), .BLK_LG2(BLK_LG2),
      .ADDR_CYCLES(ADDR_CYCLES), .COPY_LAT(COPY_LAT)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_is_addr(cmd_is_addr), .cmd_byte(cmd_byte),
      .arr_busy(arr_busy), .arr_done(arr_done),
      .arr_start(arr_start), .arr_page(arr_page),
      .copy_fire(copy_fire), .busy_n(busy_n),
      .err_flag(err_flag), .boundary_flag(boundary_flag),
      .dreg_valid(dreg_valid)
   );

   cre_array_model #(
      .PAGE_AW(PAGE_AW), .PAGE_BYTES(PAGE_BYTES), .READ_LAT(READ_LAT),
      .PAT_MUL(PAT_MUL), .PAT_STEP(PAT_STEP), .PAT_OFS(PAT_OFS)
   ) u_array (
      .clk(clk), .rst_n(rst_n),
      .start(arr_start), .page(arr_page),
      .busy(arr_busy), .done(arr_done), .row(arr_row)
   );

   cre_page_regs #(
      .PAGE_BYTES(PAGE_BYTES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .load(arr_done), .row(arr_row),
      .copy(copy_fire), .strobe(rd_strobe), .ready(busy_n),
      .rd_data(rd_data)
   );
endmodule

// File: rtl/cre_checker.sv
module cre_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_is_addr,
   input logic [7:0] cmd_byte,
   input logic [7:0] rd_data,
   input logic       busy_n,
   input logic       err_flag,
   input logic       boundary_flag,
   input logic       copy_fire,
   input logic       arr_busy,
   input logic       dreg_valid
);
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag);

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_flag) |-> $past(cmd_valid && !cmd_is_addr &&
                                (cmd_byte == 8'h31 || cmd_byte == 8'h3F)));

   assert_busy_after_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fire |=> !busy_n);

   assert_copy_consumes_page_R7: assert property (@(posedge clk) disable iff (!rst_n)
      copy_fire |=> !dreg_valid);

   assert_output_frozen_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_n && !copy_fire) |=> $stable(rd_data));

   assert_boundary_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary_flag && !(cmd_valid && !cmd_is_addr && cmd_byte == 8'h30))
      |=> boundary_flag);

   assert_boundary_no_prefetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boundary_flag) |-> !arr_busy);
endmodule

bind cache_read_engine cre_checker i_chk (
   .clk(clk), .rst_n(rst_n),
   .cmd_valid(cmd_valid), .cmd_is_addr(cmd_is_addr), .cmd_byte(cmd_byte),
   .rd_data(rd_data), .busy_n(busy_n),
   .err_flag(err_flag), .boundary_flag(boundary_flag),
   .copy_fire(copy_fire), .arr_busy(arr_busy), .dreg_valid(dreg_valid)
);

// File: tb/test_cache_read_engine.sv
module test_cache_read_engine;
   localparam int CLK_PERIOD = 10;
   localparam int PB  = 8;
   localparam int RL  = 12;
   localparam int CL  = 3;
   localparam int BLK = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_is_addr = 1'b0;
   logic [7:0] cmd_byte = 8'h00;
   logic       rd_strobe = 1'b0;
   logic [7:0] rd_data;
   logic       busy_n, err_flag, boundary_flag;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int last_acc = 0;
   int bg_done = -1000;
   int exp_rd = 0;

   cache_read_engine #(
      .PAGE_BYTES(PB), .PAGE_AW(10), .BLK_LG2(2),
      .READ_LAT(RL), .COPY_LAT(CL)
   ) i_cache_read_engine (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_is_addr(cmd_is_addr), .cmd_byte(cmd_byte),
      .rd_strobe(rd_strobe), .rd_data(rd_data), .busy_n(busy_n),
      .err_flag(err_flag), .boundary_flag(boundary_flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic int pat(int p, int c);
      return (p * 37 + c * 5 + 1) & 255;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send(bit is_a, logic [7:0] b);
      cmd_valid = 1'b1; cmd_is_addr = is_a; cmd_byte = b;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_is_addr = 1'b0; cmd_byte = 8'h00;
      last_acc = cyc;
   endtask

   task automatic wait_ready(output int n, input bit strobe_on);
      n = 0;
      rd_strobe = strobe_on;
      while (!busy_n && n < 5000) begin
         n++;
         @(negedge clk);
      end
      rd_strobe = 1'b0;
   endtask

   task automatic read_page(int p, int n);
      for (int i = 0; i < n; i++) begin
         chk(rd_data == 8'(pat(p, i % PB)), "R4 byte", rd_data, pat(p, i % PB));
         rd_strobe = 1'b1;
         @(negedge clk);
         rd_strobe = 1'b0;
      end
      exp_rd = pat(p, n % PB);
   endtask

   task automatic normal_read(int p);
      int n;
      int prev;
      prev = exp_rd;
      send(1'b0, 8'h00);
      send(1'b1, 8'(p & 255));
      send(1'b1, 8'((p >> 8) & 255));
      send(1'b0, 8'h30);
      wait_ready(n, 1'b0);
      chk(n == RL, "R2 busy length", n, RL);
      chk(rd_data == 8'(prev), "R2 cache unchanged", rd_data, prev);
      chk(boundary_flag == 1'b0, "R9 cleared by 30h", boundary_flag, 0);
      bg_done = -1000;
   endtask

   task automatic copy_cmd(logic [7:0] op, int newp, bit strobe_on);
      int n;
      int k;
      int cedge;
      bit waited;
      bit bexp;
      send(1'b0, op);
      k = last_acc;
      waited = (k <= bg_done);
      cedge = waited ? bg_done + 1 : k;
      wait_ready(n, strobe_on);
      if (waited) chk(n == cedge + CL - k, "R5 busy until load plus copy", n, cedge + CL - k);
      else if (op == 8'h3F) chk(n == CL, "R7 last copy busy", n, CL);
      else chk(n == CL, "R3 copy busy", n, CL);
      chk(rd_data == 8'(pat(newp, 0)), "R6 column zero after copy", rd_data, pat(newp, 0));
      bexp = (op == 8'h31) && (((newp + 1) % BLK) == 0);
      chk(boundary_flag == bexp, "R9 boundary flag", boundary_flag, bexp);
      if (op == 8'h31 && !bexp) bg_done = cedge + RL;
      else bg_done = -1000;
      exp_rd = pat(newp, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int p;
      int nread;
      repeat (3) @(negedge clk);
      chk(busy_n == 1'b1, "R1 busy_n", busy_n, 1);
      chk(err_flag == 1'b0, "R1 err", err_flag, 0);
      chk(boundary_flag == 1'b0, "R1 boundary", boundary_flag, 0);
      chk(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: stray confirm and unknown opcode from idle
      send(1'b0, 8'h30);
      chk(busy_n == 1'b1, "R10 stray 30h", busy_n, 1);
      send(1'b0, 8'h77);
      chk(busy_n == 1'b1, "R10 unknown opcode", busy_n, 1);
      chk(err_flag == 1'b0, "R10 no error", err_flag, 0);

      for (int sp = 0; sp < 8; sp++) begin
         normal_read(sp);
         p = sp;
         copy_cmd(8'h31, p, 1'b0);
         if (sp == 6) begin
            // R10: a new read is refused while the prefetch runs
            send(1'b0, 8'h00);
            send(1'b1, 8'h05);
            send(1'b1, 8'h00);
            send(1'b0, 8'h30);
            chk(busy_n == 1'b1, "R10 00h ignored during prefetch", busy_n, 1);
         end
         forever begin
            nread = (sp == 2 && p == sp) ? 3 : PB + 1;
            read_page(p, nread);
            if (((p + 1) % BLK) == 0) break;
            if ((sp % 2) == 1 && p == sp) begin
               copy_cmd(8'h3F, p + 1, 1'b0);
               p++;
               read_page(p, PB + 1);
               break;
            end
            copy_cmd(8'h31, p + 1, sp == 4);
            p++;
         end
         chk(err_flag == 1'b0, "R8 no spurious error", err_flag, 0);
      end

      // R7 and R8: after 3Fh nothing is pending, so the next cache command finds no page
      normal_read(9);
      copy_cmd(8'h31, 9, 1'b0);
      read_page(9, 2);
      copy_cmd(8'h3F, 10, 1'b0);
      read_page(10, 3);
      repeat (RL + 4) @(negedge clk);
      send(1'b0, 8'h31);
      chk(busy_n == 1'b1, "R7 no load after last copy", busy_n, 1);
      chk(err_flag == 1'b1, "R8 error set", err_flag, 1);
      chk(rd_data == 8'(exp_rd), "R8 output unchanged", rd_data, exp_rd);
      send(1'b0, 8'h3F);
      chk(busy_n == 1'b1, "R8 3Fh ignored", busy_n, 1);
      chk(rd_data == 8'(exp_rd), "R8 output unchanged 3Fh", rd_data, exp_rd);
      repeat (5) @(negedge clk);
      chk(err_flag == 1'b1, "R8 error sticky", err_flag, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule